// File: doc/BRIEF.md
# Three-Wire Converter Control Serializer

This block turns one register write for an audio converter into a serial frame on a three-line control link: a data line, a bit clock and a load strobe. The requester offers a 7-bit register address and a 9-bit value with a valid/ready handshake. The block packs them into one 16-bit word and shifts the word out most significant bit first. The converter samples data on each rising clock edge. After the last bit, a separate load strobe rises to commit the word, and then the link is parked with all three lines high.

Timing comes from one parameter, `HALF_CYCLES`. It is the number of system clock cycles in every link phase (one half-bit). Its default of 250 gives 1 µs per phase at a 250 MHz system clock. A frame has 34 phases. The block holds `req_ready` low for the whole frame. It then raises a one-cycle `frame_done` pulse, and only after that pulse does it take the next request.

Top module: `codec3w_serializer`

## Requirements
- R1: The transmitted word is `{req_addr[6:0], req_data[8:0]}`: the address occupies word bits 15..9 and the value occupies bits 8..0. Bit 15 is sent first. The receiver captures one bit on each rising edge of `link_clk` while `link_load` is low.
- R2: After a synchronous reset, including a reset in the middle of a frame, `link_data`, `link_clk` and `link_load` are all 1, `req_ready` is 1 and `frame_done` is 0.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the cycle after that edge, all three link lines are 0 and `req_ready` is 0.
- R4: Counting the accept edge as cycle 0, the link moves through consecutive phases of `HALF_CYCLES` cycles each. Phase 0 holds all lines low. Phase 2i+1 (i = 0..15) holds the clock low with data equal to word bit 15-i. Phase 2i+2 holds the clock high with the same data.
- R5: Each frame has exactly 16 rising edges of `link_clk` while `link_load` is low.
- R6: `link_load` stays low from the accept until phase 33, which starts `HALF_CYCLES` cycles after the sixteenth rising clock edge. During phase 33 `link_load` is high, the clock is high and data still holds word bit 0.
- R7: At cycle 34·`HALF_CYCLES`, data and clock go high with load still high, and `frame_done` is 1 for exactly that one cycle.
- R8: `req_ready` stays 0 from the accept through the `frame_done` cycle. A request offered while `req_ready` is 0 is ignored: it neither changes the frame in flight nor starts another frame.
- R9: `req_ready` returns to 1 at cycle 34·`HALF_CYCLES`+1. Every link phase lasts exactly `HALF_CYCLES` cycles.
- R10: A request that is held valid across the end of a frame is accepted on the edge right after the cycle where `req_ready` returns to 1. Its frame then starts with no extra idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | 7 | Converter register address |
| req_data | input | 9 | Value to write |
| frame_done | output | 1 | One-cycle pulse when the frame is complete |
| link_data | output | 1 | Serial data line |
| link_clk | output | 1 | Serial bit clock; the receiver samples on its rising edge |
| link_load | output | 1 | Load strobe that commits the word; high when idle |

## Verification
Every link output comes from registered phase state through combinational decode. A change therefore shows up in the cycle right after the edge that causes it. The bench counts from the accept edge as cycle 0 and derives the expected levels of all three lines from phase = cycle / `HALF_CYCLES`. It expects `frame_done` at cycle 34·`HALF_CYCLES` and `req_ready` back at the following cycle. Outputs are sampled on the falling edge of every cycle of the frame. The word is rebuilt independently from the observed clock rises. This lets the bench detect an off-by-one phase length, a misplaced load strobe and a wrong bit order, each as a separate failure.

// File: rtl/codec3w_pkg.sv
package codec3w_pkg;

  // Link phases; each busy phase lasts one half-bit period.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_LATCH = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  // Bit clock level for a phase: parked high, low while data settles.
  function automatic logic phase_clk_level(input phase_e ph);
    case (ph)
      PH_IDLE, PH_HIGH, PH_LATCH, PH_DONE: phase_clk_level = 1'b1;
      default:                             phase_clk_level = 1'b0;
    endcase
  endfunction

  // Load strobe level: high only while committing or parked.
  function automatic logic phase_load_level(input phase_e ph);
    case (ph)
      PH_IDLE, PH_LATCH, PH_DONE: phase_load_level = 1'b1;
      default:                    phase_load_level = 1'b0;
    endcase
  endfunction

  // Data line: forced low at frame start, high when parked, else the bit.
  function automatic logic phase_data_level(input phase_e ph, input logic bit_val);
    case (ph)
      PH_IDLE, PH_DONE: phase_data_level = 1'b1;
      PH_START:         phase_data_level = 1'b0;
      default:          phase_data_level = bit_val;
    endcase
  endfunction

  // A phase in which the half-bit timer runs.
  function automatic logic phase_timed(input phase_e ph);
    case (ph)
      PH_START, PH_LOW, PH_HIGH, PH_LATCH: phase_timed = 1'b1;
      default:                             phase_timed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/codec3w_half_timer.sv
module codec3w_half_timer #(
  parameter int HALF_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(HALF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/codec3w_shifter.sv
module codec3w_shifter #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              msb
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  // Address in the upper field, value in the lower field.
  function automatic logic [FRAME_W-1:0] pack_word(input logic [ADDR_W-1:0] a,
                                                   input logic [DATA_W-1:0] d);
    pack_word = {a, d};
  endfunction

  logic [FRAME_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)           word_q <= '0;
    else if (load_en)  word_q <= pack_word(addr, data);
    else if (shift_en) word_q <= {word_q[FRAME_W-2:0], 1'b0};
  end

  assign msb = word_q[FRAME_W-1];
endmodule

// File: rtl/codec3w_sequencer.sv
module codec3w_sequencer
  import codec3w_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   tick,
  output phase_e phase,
  output logic   shift_en,
  output logic   timer_run
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);

  phase_e           ph_q, ph_d;
  logic [BIT_W-1:0] idx_q, idx_d;
  logic             last_bit;

  assign last_bit = (idx_q == LAST_IDX);

  always_comb begin
    ph_d     = ph_q;
    idx_d    = idx_q;
    shift_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_START;
          idx_d = '0;
        end
      end
      PH_START: if (tick) ph_d = PH_LOW;
      PH_LOW:   if (tick) ph_d = PH_HIGH;
      PH_HIGH: begin
        if (tick) begin
          if (last_bit) begin
            ph_d = PH_LATCH;
          end else begin
            ph_d     = PH_LOW;
            idx_d    = idx_q + BIT_W'(1);
            shift_en = 1'b1;
          end
        end
      end
      PH_LATCH: if (tick) ph_d = PH_DONE;
      PH_DONE:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  assign phase     = ph_q;
  assign timer_run = phase_timed(ph_q);
endmodule

// File: rtl/codec3w_serializer.sv
module codec3w_serializer
  import codec3w_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 9,
  parameter int HALF_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              frame_done,
  output logic              link_data,
  output logic              link_clk,
  output logic              link_load
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  // Named internal events, also used by the bound checker.
  phase_e phase;
  logic   accept;
  logic   half_tick;
  logic   shift_en;
  logic   timer_run;
  logic   cur_bit;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  codec3w_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (timer_run),
    .tick  (half_tick)
  );

  codec3w_sequencer #(.FRAME_W(FRAME_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .tick      (half_tick),
    .phase     (phase),
    .shift_en  (shift_en),
    .timer_run (timer_run)
  );

  codec3w_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_en  (accept),
    .shift_en (shift_en),
    .addr     (req_addr),
    .data     (req_data),
    .msb      (cur_bit)
  );

  assign link_clk   = phase_clk_level(phase);
  assign link_load  = phase_load_level(phase);
  assign link_data  = phase_data_level(phase, cur_bit);
  assign frame_done = (phase == PH_DONE);
endmodule

// File: rtl/codec3w_checker.sv
module codec3w_checker #(
  parameter int FRAME_W     = 16,
  parameter int HALF_CYCLES = 250
) (
  input logic clk,
  input logic rst,
  input logic accept,
  input logic half_tick,
  input logic req_ready,
  input logic frame_done,
  input logic link_data,
  input logic link_clk,
  input logic link_load
);
  logic        clk_q, load_q;
  logic [7:0]  rise_cnt;
  logic [31:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q    <= 1'b1;
      load_q   <= 1'b1;
      rise_cnt <= '0;
      gap_cnt  <= '0;
    end else begin
      clk_q  <= link_clk;
      load_q <= link_load;
      if (load_q && !link_load)                    rise_cnt <= '0;
      else if (link_clk && !clk_q && !link_load)   rise_cnt <= rise_cnt + 8'd1;
      if (accept || half_tick) gap_cnt <= '0;
      else                     gap_cnt <= gap_cnt + 32'd1;
    end
  end

  assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!link_clk && !link_data && !link_load && !req_ready));

  assert_data_held_R4: assert property (@(posedge clk) disable iff (rst)
    (link_clk && $past(link_clk) && !link_load) |-> $stable(link_data));

  assert_rise_count_R5: assert property (@(posedge clk) disable iff (rst)
    (link_load && !load_q) |-> (rise_cnt == 8'(FRAME_W)));

  assert_done_park_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (link_clk && link_data && link_load && !req_ready));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (!frame_done && req_ready));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !frame_done) |=> !req_ready);

  assert_half_period_R9: assert property (@(posedge clk) disable iff (rst)
    half_tick |-> (gap_cnt == 32'(HALF_CYCLES - 1)));
endmodule

bind codec3w_serializer codec3w_checker #(
  .FRAME_W     (ADDR_W + DATA_W),
  .HALF_CYCLES (HALF_CYCLES)
) u_codec3w_checker (
  .clk        (clk),
  .rst        (rst),
  .accept     (accept),
  .half_tick  (half_tick),
  .req_ready  (req_ready),
  .frame_done (frame_done),
  .link_data  (link_data),
  .link_clk   (link_clk),
  .link_load  (link_load)
);

// File: tb/test_codec3w_serializer.sv
module test_codec3w_serializer;
  localparam int HC      = 5;
  localparam int FRAME_T = 34 * HC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [6:0] req_addr = '0;
  logic [8:0] req_data = '0;
  logic       req_ready, frame_done, link_data, link_clk, link_load;

  int pass_cnt = 0;
  int fail_cnt = 0;

  always #2 clk = ~clk;

  codec3w_serializer #(.HALF_CYCLES(HC)) i_codec3w_serializer (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .frame_done (frame_done),
    .link_data  (link_data),
    .link_clk   (link_clk),
    .link_load  (link_load)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Idle link for n cycles: all high, ready, no done pulse.
  task automatic check_idle(input int n, input string req);
    bit bad = 0;
    logic [3:0] seen = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!(link_data && link_clk && link_load && req_ready && !frame_done)) begin
        bad = 1;
        seen = {link_data, link_clk, link_load, frame_done};
      end
    end
    chk(!bad, req, "idle lines high, no new frame", {28'd0, seen}, 32'he);
  endtask

  // Called at the falling edge right after the accept edge (cycle 0).
  task automatic check_frame(input logic [6:0] a, input logic [8:0] d,
                             input bit next_v, input logic [6:0] na,
                             input logic [8:0] nd, input bit poke);
    logic [15:0] word;
    logic [15:0] got;
    int   rises;
    bit   bad4, bad6, bad8;
    logic [31:0] a4, e4, a6, e6;
    logic prev_clk;
    word = {a, d};
    got = '0; rises = 0; bad4 = 0; bad6 = 0; bad8 = 0;
    a4 = '0; e4 = '0; a6 = '0; e6 = '0;
    chk(!link_data && !link_clk && !link_load && !req_ready, "R3",
        "lines low and ready low after accept",
        {28'd0, link_data, link_clk, link_load, req_ready}, 32'h0);
    req_valid = next_v; req_addr = na; req_data = nd;
    prev_clk = link_clk;
    for (int k = 1; k <= FRAME_T + 1; k++) begin
      @(negedge clk);
      if (k < FRAME_T) begin
        int ph;
        logic ec, ed, el;
        ph = k / HC;
        ec = ((ph != 0) && (ph % 2 == 0)) || (ph == 33);
        ed = (ph == 0) ? 1'b0 : (ph == 33) ? word[0] : word[15 - (ph - 1) / 2];
        el = (ph == 33);
        if ((link_clk !== ec || link_data !== ed) && !bad4) begin
          bad4 = 1; a4 = {k[23:0], 6'd0, link_clk, link_data}; e4 = {k[23:0], 6'd0, ec, ed};
        end
        if (link_load !== el && !bad6) begin
          bad6 = 1; a6 = {k[30:0], link_load}; e6 = {k[30:0], el};
        end
        if (req_ready !== 1'b0) bad8 = 1;
        if (!prev_clk && link_clk && !link_load) begin
          got = {got[14:0], link_data};
          rises++;
        end
      end else if (k == FRAME_T) begin
        if (req_ready !== 1'b0) bad8 = 1;
        chk(frame_done && link_data && link_clk && link_load, "R7",
            "done pulse with lines parked high",
            {28'd0, frame_done, link_data, link_clk, link_load}, 32'hf);
      end else begin
        chk(req_ready && !frame_done, "R9", "ready back one cycle after done",
            {30'd0, req_ready, frame_done}, 32'h2);
      end
      prev_clk = link_clk;
      if (poke && k == 10 * HC) begin
        req_valid = 1'b1; req_addr = ~a; req_data = ~d;
      end
      if (poke && k == 10 * HC + 1) req_valid = 1'b0;
    end
    chk(got == word, "R1", "captured word", {16'd0, got}, {16'd0, word});
    chk(rises == 16, "R5", "rising clock edges per frame", rises, 32'd16);
    chk(!bad4, "R4", "clock/data phase levels {cycle,clk,data}", a4, e4);
    chk(!bad6, "R6", "load strobe timing {cycle,load}", a6, e6);
    chk(!bad8, "R8", "ready low through frame", {31'd0, bad8}, 32'd0);
  endtask

  task automatic start_req(input logic [6:0] a, input logic [8:0] d);
    @(negedge clk);
    chk(req_ready, "R8", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(link_data && link_clk && link_load && req_ready && !frame_done, "R2",
        "reset idle state",
        {27'd0, link_data, link_clk, link_load, req_ready, frame_done}, 32'h1e);
  endtask

  task automatic test_frame(input logic [6:0] a, input logic [8:0] d);
    start_req(a, d);
    check_frame(a, d, 1'b0, '0, '0, 1'b0);
    check_idle(2 * HC, "R8");
  endtask

  task automatic test_busy_ignored();
    start_req(7'h13, 9'h0c6);
    check_frame(7'h13, 9'h0c6, 1'b0, '0, '0, 1'b1);
    check_idle(3 * HC, "R8");
  endtask

  task automatic test_back_to_back();
    start_req(7'h61, 9'h10f);
    check_frame(7'h61, 9'h10f, 1'b1, 7'h0e, 9'h0f3, 1'b0);
    @(negedge clk);
    // R10: accepted on the edge right after ready returned
    check_frame(7'h0e, 9'h0f3, 1'b0, '0, '0, 1'b0);
    check_idle(2 * HC, "R10");
  endtask

  task automatic test_mid_reset();
    start_req(7'h7f, 9'h000);
    req_valid = 1'b0;
    repeat (7 * HC) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(link_data && link_clk && link_load && req_ready && !frame_done, "R2",
        "mid-frame reset returns idle",
        {27'd0, link_data, link_clk, link_load, req_ready, frame_done}, 32'h1e);
    check_idle(3 * HC, "R2");
    test_frame(7'h44, 9'h101);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_frame(7'h00, 9'h000);
    test_frame(7'h7f, 9'h1ff);
    test_frame(7'h55, 9'h0aa);
    test_frame(7'h2a, 9'h155);
    test_busy_ignored();
    test_back_to_back();
    test_mid_reset();
    finish_run();
  end
endmodule